// File: doc/BRIEF.md
# Dual-Memory FIR Tap Sequencer

This block computes one output of a finite impulse response filter per request. It holds the coefficients and a circular buffer of past input samples in two separate register arrays, each with its own address pointer and read path, so one coefficient and one sample are fetched in the same cycle. The fetch of each operand pair overlaps the multiply-accumulate of the pair fetched one cycle earlier. This keeps the multiplier and both read paths busy on every cycle of a computation.

A start pulse carries a new input sample and a tap count N. The sample becomes the newest entry x[n] of the delay buffer, and the accumulator is cleared. N coefficient/sample pairs b[k]·x[n-k] are then summed in signed Q1.23 fractional arithmetic into a 56-bit accumulator that has 8 guard bits. The saturated high word is returned with a one-cycle done pulse. Coefficients are loaded through a simple write port while the sequencer is idle.

Top module: `fir_tap_seq`

## Requirements
- R1: After reset, busy, done and result are 0, and every entry of the sample buffer reads as zero (x[n-k] = 0 for samples never written).
- R2: A start accepted while idle with 1 ≤ tap_count ≤ TAPS_MAX writes sample_in as x[n]. The result is then floor(2·Σ b[k]·x[n-k] / 2^23) for k = 0..N-1, where b[k] is the coefficient at address k and all values are signed Q1.23 in two's complement.
- R3: done is high for exactly one cycle, at the (N+2)-th rising edge after the edge that accepts start. busy is high from the accepting edge until that same edge.
- R4: A start pulse while busy is high is ignored: no sample is written and the running result is unchanged.
- R5: A start with tap_count = 0 or tap_count > TAPS_MAX is ignored: busy stays low and no sample is written.
- R6: A result above 0x7FFFFF saturates to 0x7FFFFF and a result below −2^23 saturates to 0x800000. This includes the product (−1)·(−1).
- R7: The sample buffer is circular with BUF_LEN entries. The newest BUF_LEN samples are kept, and x[n-k] is read correctly across the wrap point.
- R8: result keeps its value from one done pulse until the next.
- R9: coef_we writes coef_wdata to the coefficient at coef_addr, and later computations use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 3 | Coefficient index k |
| coef_wdata | input | 24 | Coefficient value, Q1.23 |
| start | input | 1 | Request one output |
| tap_count | input | 4 | Number of taps N |
| sample_in | input | 24 | New input sample x[n], Q1.23 |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | 24 | Saturated output, Q1.23 |

## Verification
The assertions assume that start is a single-cycle request. They also assume that coefficient writes happen only while busy is low, because a write in the middle of a computation could change a tap that has not yet been fetched. The directed tasks load coefficients only between computations. They raise start for one cycle, except where they deliberately pulse it during busy or with an out-of-range tap count. The reference sum is formed in 64-bit integers from the history of samples pushed by the bench.

// File: rtl/fir_tap_seq.sv
module fir_tap_seq #(
  parameter int DW       = 24,
  parameter int GUARD    = 8,
  parameter int TAPS_MAX = 8,
  parameter int BUF_LEN  = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          coef_we,
  input  logic [$clog2(TAPS_MAX)-1:0]   coef_addr,
  input  logic [DW-1:0]                 coef_wdata,
  input  logic                          start,
  input  logic [$clog2(TAPS_MAX+1)-1:0] tap_count,
  input  logic [DW-1:0]                 sample_in,
  output logic                          busy,
  output logic                          done,
  output logic [DW-1:0]                 result
);
  localparam int AC    = $clog2(TAPS_MAX);
  localparam int CW    = $clog2(TAPS_MAX+1);
  localparam int SW    = $clog2(BUF_LEN);
  localparam int ACC_W = 2*DW + GUARD;
  localparam logic signed [ACC_W-1:0] HI_LIM = ACC_W'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [ACC_W-1:0] LO_LIM = -ACC_W'(64'sd1 <<< (DW-1));

  logic [DW-1:0] coef [TAPS_MAX];
  logic [DW-1:0] sbuf [BUF_LEN];

  logic [AC-1:0] cptr;
  logic [SW-1:0] sptr, head;
  logic [CW-1:0] fcnt, ntaps;
  logic          fetching, v_q, l_q, fin;
  logic [DW-1:0] c_q, s_q;
  logic signed [ACC_W-1:0] acc;

  wire accept = start && !busy && tap_count != '0 && tap_count <= CW'(TAPS_MAX);

  wire signed [2*DW-1:0]  prod   = $signed(c_q) * $signed(s_q);
  wire signed [ACC_W-1:0] prod_x = ACC_W'(prod) <<< 1;
  wire signed [ACC_W-1:0] shv    = acc >>> (DW-1);
  wire [DW-1:0] sat = (shv > HI_LIM) ? {1'b0, {(DW-1){1'b1}}} :
                      (shv < LO_LIM) ? {1'b1, {(DW-1){1'b0}}} : shv[DW-1:0];

  always_ff @(posedge clk)
    if (coef_we) coef[coef_addr] <= coef_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_LEN; i++) sbuf[i] <= '0;
      head <= '0;
    end else if (accept) begin
      sbuf[head] <= sample_in;
      head <= (head == '0) ? SW'(BUF_LEN-1) : head - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; fetching <= 1'b0; v_q <= 1'b0; l_q <= 1'b0; fin <= 1'b0;
      done <= 1'b0; result <= '0; acc <= '0;
      cptr <= '0; sptr <= '0; fcnt <= '0; ntaps <= '0; c_q <= '0; s_q <= '0;
    end else begin
      if (accept) begin
        busy <= 1'b1; fetching <= 1'b1; acc <= '0;
        cptr <= '0; sptr <= head; fcnt <= '0; ntaps <= tap_count;
      end
      if (fetching) begin
        c_q  <= coef[cptr];
        s_q  <= sbuf[sptr];
        v_q  <= 1'b1;
        l_q  <= (fcnt == ntaps - 1'b1);
        cptr <= cptr + 1'b1;
        sptr <= (sptr == SW'(BUF_LEN-1)) ? '0 : sptr + 1'b1;
        fcnt <= fcnt + 1'b1;
        if (fcnt == ntaps - 1'b1) fetching <= 1'b0;
      end else begin
        v_q <= 1'b0;
        l_q <= 1'b0;
      end
      if (v_q) acc <= acc + prod_x;
      fin  <= v_q && l_q;
      done <= fin;
      if (fin) begin
        result <= sat;
        busy   <= 1'b0;
      end
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && $past(busy));
  p_busy_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  p_bad_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (tap_count == '0 || tap_count > CW'(TAPS_MAX))) |=> !busy);
  p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sptr < SW'(BUF_LEN) && head < SW'(BUF_LEN));
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result));
endmodule

// File: tb/tb_fir_tap_seq.sv
module tb_fir_tap_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS_MAX = 8;

  logic clk = 0, rst_n = 0, coef_we = 0, start = 0;
  logic [2:0] coef_addr = 0;
  logic [23:0] coef_wdata = 0, sample_in = 0;
  logic [3:0] tap_count = 0;
  logic busy, done;
  logic [23:0] result;

  fir_tap_seq dut (.clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_wdata(coef_wdata), .start(start), .tap_count(tap_count), .sample_in(sample_in),
    .busy(busy), .done(done), .result(result));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  longint cf [TAPS_MAX];
  longint hist [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [23:0] v);
    return longint'($signed(v));
  endfunction

  function automatic logic [23:0] model(input int n);
    longint s = 0, v;
    for (int k = 0; k < n; k++)
      if (k < hist.size()) s += cf[k] * hist[hist.size()-1-k];
    v = (s * 2) >>> 23;
    if (v > 64'sd8388607) v = 64'sd8388607;
    if (v < -64'sd8388608) v = -64'sd8388608;
    return v[23:0];
  endfunction

  task automatic load(input int k, input logic [23:0] v);
    @(negedge clk);
    coef_we = 1; coef_addr = 3'(k); coef_wdata = v;
    @(negedge clk);
    coef_we = 0;
    cf[k] = sx(v);
  endtask

  task automatic run(input int n, input logic [23:0] smp, input bit inject, input string req);
    logic [23:0] exp;
    bit early = 0;
    @(negedge clk);
    start = 1; tap_count = 4'(n); sample_in = smp;
    @(posedge clk);
    hist.push_back(sx(smp));
    exp = model(n);
    @(negedge clk);
    start = 0;
    for (int i = 1; i <= n + 2; i++) begin
      @(posedge clk); #1;
      if (i < n + 2 && (done || !busy)) early = 1;
      if (inject && i == 1) begin start = 1; tap_count = 4'd2; sample_in = 24'h123456; end
      if (inject && i == 2) start = 0;
    end
    check(!early, {req, " R3 busy held, no early done"}, longint'(early), 0);
    check(done === 1'b1 && busy === 1'b0, {req, " R3 done at N+2"}, longint'(done), 1);
    check(result === exp, req, longint'(result), longint'(exp));
    @(posedge clk); #1;
    check(done === 1'b0, {req, " R3 done one cycle"}, longint'(done), 0);
    check(result === exp, {req, " R8 result held"}, longint'(result), longint'(exp));
  endtask

  task automatic t_reset();
    check(busy === 0 && done === 0 && result === 0, "R1 reset outputs",
          longint'({busy, done, result}), 0);
  endtask

  task automatic t_basic();
    load(0, 24'h400000); load(1, 24'h200000); load(2, 24'hE00000); load(3, 24'h100000);
    run(4, 24'h300000, 0, "R1 cleared buffer first output");
    run(4, 24'hC00000, 0, "R2 four-tap");
    run(4, 24'h0A0000, 0, "R2 four-tap");
    run(1, 24'h7FFFFF, 0, "R2 single tap");
  endtask

  task automatic t_busy_start();
    run(4, 24'h111111, 1, "R4 start during busy ignored");
    run(4, 24'h050505, 0, "R4 ignored sample not in history");
  endtask

  task automatic t_bad_count();
    foreach (tap_count[i]) ;
    @(negedge clk); start = 1; tap_count = 4'd0; sample_in = 24'h654321;
    @(negedge clk); tap_count = 4'd9;
    @(negedge clk); start = 0;
    @(posedge clk); #1;
    check(busy === 0 && done === 0, "R5 bad tap count ignored", longint'(busy), 0);
    run(4, 24'h020000, 0, "R5 bad starts wrote nothing");
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 4; k++) load(k, 24'h7FFFFF);
    for (int i = 0; i < 4; i++) run(4, 24'h7FFFFF, 0, "R6 positive saturation");
    check(result === 24'h7FFFFF, "R6 clamp high", longint'(result), 24'h7FFFFF);
    for (int k = 0; k < 4; k++) load(k, 24'h800000);
    run(4, 24'h7FFFFF, 0, "R6 negative saturation");
    check(result === 24'h800000, "R6 clamp low", longint'(result), 24'h800000);
    run(1, 24'h800000, 0, "R6 minus one squared");
    check(result === 24'h7FFFFF, "R6 (-1)*(-1)", longint'(result), 24'h7FFFFF);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < TAPS_MAX; k++) load(k, 24'((k * 24'h0F1357) ^ 24'h0A5A5A));
    load(7, 24'hF80000);
    check(1'b1, "R9 coefficients rewritten", 0, 0);
    for (int i = 0; i < 13; i++)
      run(TAPS_MAX, 24'((i * 24'h13579B + 24'h02468A) & 24'hFFFFFF), 0, "R7 R9 wrap eight-tap");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < TAPS_MAX; k++) cf[k] = 0;
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1;
    t_basic();
    t_busy_start();
    t_bad_count();
    t_saturate();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule